// File: doc/BRIEF.md
# Bus-Cycle Breakpoint Channel with Pass Counter

This block is a single hardware breakpoint channel for an on-chip debug unit. It watches every bus cycle issued by two initiators, the CPU and the DMA controller. It compares the cycle's address, under a programmable bit mask, against a stored reference address. It also checks the initiator, the kind of access (instruction fetch or data) and the direction (read or write) against programmed selects. A cycle that satisfies all of these is a match.

Each match sets a sticky flag for the initiator that caused it. Software clears the flag by writing 0 to it. The match, or a later retirement of the matched instruction, produces a break event. An optional pass counter lets the event raise the one-cycle interrupt request only on every N-th occurrence. For instruction-fetch matches, a control bit chooses when the event is taken. With the bit at 0 it is taken at the fetch, before the instruction executes. With the bit at 1 it is taken when the instruction-complete strobe reports the same fetch address, after the instruction executes.

The register port is a simple word-select interface with single-cycle writes and combinational reads. The word selects are:

| Word | Register | Access |
|------|----------|--------|
| 0 | reference address | read/write |
| 1 | mask | read/write |
| 2 | condition selects | read/write |
| 3 | control/status | read/write |
| 4 | count target | read/write |
| 5 | live occurrence count | read only |

Top module: `bus_break_channel`

## Requirements
- R1: A bus cycle matches only when `bus_valid` is 1 and the cycle's address equals the reference address (word 0) in every bit position where the mask (word 1) holds 0. A mask bit of 1 makes that address bit a don't-care.
- R2: The condition word (word 2) is laid out as follows, and a cycle matches only if each of its three attributes is allowed. Bit 0 allows CPU cycles and bit 1 allows DMA cycles. Bit 2 allows fetch cycles and bit 3 allows data cycles. Bit 4 allows reads and bit 5 allows writes. A pair of bits that are both 0 blocks every match. Bits 31:6 read as 0.
- R3: The CPU match flag (control bit 0) goes to 1 in the cycle after a CPU-initiated match. No hardware event clears it.
- R4: The DMA match flag (control bit 1) goes to 1 in the cycle after a DMA-initiated match. No hardware event clears it.
- R5: A write to the control word clears a flag when the written bit is 0. A written 1 leaves the flag unchanged. If a match sets a flag in the same cycle that a write clears it, the flag ends at 1.
- R6: The control word keeps only bits 3:0 (bit 2 is the count enable, bit 3 is the after-execution select). Bits 31:4 always read as 0 whatever value is written.
- R7: With the count enable at 0, every break event drives `brk_irq` high for exactly the next cycle.
- R8: With the count enable at 1, each break event increments a 12-bit occurrence count (word 5). When the count would reach the target (word 4), `brk_irq` pulses instead and the count returns to 0. A target of 0 behaves like 1.
- R9: Writing the target word sets the count to 0. A break event in the same cycle is neither counted nor signalled.
- R10: With the after-execution select at 0, a fetch match is a break event in its own cycle.
- R11: With the after-execution select at 1, a fetch match is held pending. The break event occurs in the cycle where `insn_done` is 1 and `insn_done_addr` equals the pending fetch address, and the pending state then clears. A newer deferred fetch match replaces the held address. Data matches stay immediate.
- R12: After reset, all six registers read as 0 and `brk_irq` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_is_dma | input | 1 | 1 = DMA-initiated cycle, 0 = CPU-initiated cycle |
| bus_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Bus cycle address |
| insn_done | input | 1 | Instruction-complete strobe |
| insn_done_addr | input | 32 | Fetch address of the completed instruction |
| brk_irq | output | 1 | Break interrupt request, one-cycle pulse |

## Verification
Addresses are applied just inside and just outside the masked window. This separates the masked bits from the compared bits. CPU reads, DMA writes and fetches are sent under condition words that open or close one attribute at a time, so that each select bit is shown to gate the match on its own. Flag writes with mixed 0 and 1 data, including a write that coincides with a match, tell the set priority apart from the clear path. Runs of matches against a small target, and a target rewrite in the middle of a count, expose the counter's wrap and reset order. Deferred fetches retired with a wrong address and then the right one separate the pending path from the immediate one.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

  // register word selects
  typedef enum logic [2:0] {
    RS_ADDR = 3'd0,
    RS_MASK = 3'd1,
    RS_COND = 3'd2,
    RS_CTRL = 3'd3,
    RS_TGT  = 3'd4,
    RS_CNT  = 3'd5
  } reg_sel_e;

  // condition selects, bit 0 is cpu_ok
  typedef struct packed {
    logic wr_ok;
    logic rd_ok;
    logic data_ok;
    logic fetch_ok;
    logic dma_ok;
    logic cpu_ok;
  } cond_t;

  // control/status, bit 0 is cpu_flag
  typedef struct packed {
    logic after_exec;
    logic cnt_en;
    logic dma_flag;
    logic cpu_flag;
  } ctl_t;

  localparam int COND_W = $bits(cond_t);
  localparam int CTL_W  = $bits(ctl_t);

endpackage

// File: rtl/bkpt_match.sv
module bkpt_match
  import bkpt_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          bus_valid,
  input  logic          bus_is_dma,
  input  logic          bus_fetch,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  input  logic [AW-1:0] ref_addr,
  input  logic [AW-1:0] ref_mask,
  input  cond_t         cond,
  output logic          hit,
  output logic          addr_ok
);

  // mask bit 1 = don't care
  function automatic logic addr_hit(input logic [AW-1:0] a,
                                    input logic [AW-1:0] r,
                                    input logic [AW-1:0] m);
    return ((a ^ r) & ~m) == '0;
  endfunction

  function automatic logic attr_ok(input cond_t c, input logic dma,
                                   input logic fetch, input logic wr);
    logic i_ok, t_ok, d_ok;
    i_ok = dma   ? c.dma_ok  : c.cpu_ok;
    t_ok = fetch ? c.fetch_ok : c.data_ok;
    d_ok = wr    ? c.wr_ok   : c.rd_ok;
    return i_ok & t_ok & d_ok;
  endfunction

  logic attr_pass;

  assign addr_ok   = addr_hit(bus_addr, ref_addr, ref_mask);
  assign attr_pass = attr_ok(cond, bus_is_dma, bus_fetch, bus_write);
  assign hit       = bus_valid & addr_ok & attr_pass;

  // R1: a hit always has a compatible address
  always_comb begin
    a_r1_hit_needs_addr: assert (!hit || addr_ok);
  end

endmodule

// File: rtl/bkpt_regs.sv
module bkpt_regs
  import bkpt_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  input  logic          cpu_set,
  input  logic          dma_set,
  input  logic [CW-1:0] occ_count,
  output logic [AW-1:0] ref_addr,
  output logic [AW-1:0] ref_mask,
  output cond_t         cond,
  output logic          cnt_en,
  output logic          after_exec,
  output logic [CW-1:0] target,
  output logic          target_wr
);

  localparam int PAD_COND = AW - COND_W;
  localparam int PAD_CTL  = AW - CTL_W;
  localparam int PAD_CNT  = AW - CW;

  reg_sel_e sel;
  ctl_t     ctl_q, ctl_d;
  logic     ctrl_wr;

  assign sel       = reg_sel_e'(reg_addr);
  assign ctrl_wr   = reg_we && (sel == RS_CTRL);
  assign target_wr = reg_we && (sel == RS_TGT);

  // flags: write of 0 clears, hardware set wins
  always_comb begin
    ctl_d = ctl_q;
    if (ctrl_wr) begin
      ctl_d.cpu_flag   = ctl_q.cpu_flag & reg_wdata[0];
      ctl_d.dma_flag   = ctl_q.dma_flag & reg_wdata[1];
      ctl_d.cnt_en     = reg_wdata[2];
      ctl_d.after_exec = reg_wdata[3];
    end
    ctl_d.cpu_flag = ctl_d.cpu_flag | cpu_set;
    ctl_d.dma_flag = ctl_d.dma_flag | dma_set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_addr <= '0;
      ref_mask <= '0;
      cond     <= '0;
      ctl_q    <= '0;
      target   <= '0;
    end else begin
      ctl_q <= ctl_d;
      if (reg_we) begin
        case (sel)
          RS_ADDR: ref_addr <= reg_wdata;
          RS_MASK: ref_mask <= reg_wdata;
          RS_COND: cond     <= cond_t'(reg_wdata[COND_W-1:0]);
          RS_TGT:  target   <= reg_wdata[CW-1:0];
          default: ;
        endcase
      end
    end
  end

  assign cnt_en     = ctl_q.cnt_en;
  assign after_exec = ctl_q.after_exec;

  always_comb begin
    case (sel)
      RS_ADDR: reg_rdata = ref_addr;
      RS_MASK: reg_rdata = ref_mask;
      RS_COND: reg_rdata = {{PAD_COND{1'b0}}, cond};
      RS_CTRL: reg_rdata = {{PAD_CTL{1'b0}}, ctl_q};
      RS_TGT:  reg_rdata = {{PAD_CNT{1'b0}}, target};
      RS_CNT:  reg_rdata = {{PAD_CNT{1'b0}}, occ_count};
      default: reg_rdata = '0;
    endcase
  end

  // R3: a CPU match always leaves the flag set
  a_r3_cpu_set: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_set |=> ctl_q.cpu_flag);
  // R4: a DMA match always leaves the flag set
  a_r4_dma_set: assert property (@(posedge clk) disable iff (!rst_n)
    dma_set |=> ctl_q.dma_flag);
  // R5: a flag only falls after a software write of 0 with no match
  a_r5_cpu_clear_src: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_q.cpu_flag) |-> $past(ctrl_wr && !reg_wdata[0] && !cpu_set));
  a_r5_dma_clear_src: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_q.dma_flag) |-> $past(ctrl_wr && !reg_wdata[1] && !dma_set));
  // R6: upper control bits read back as zero
  always_comb begin
    a_r6_ctrl_reserved: assert (sel != RS_CTRL || reg_rdata[AW-1:CTL_W] == '0);
  end

endmodule

// File: rtl/bkpt_exec_track.sv
module bkpt_exec_track #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  logic          bus_fetch,
  input  logic [AW-1:0] bus_addr,
  input  logic          after_exec,
  input  logic          insn_done,
  input  logic [AW-1:0] insn_done_addr,
  output logic          brk_event,
  output logic          pending
);

  logic [AW-1:0] pend_addr;
  logic          defer, immed, retire;

  assign defer     = hit & bus_fetch & after_exec;
  assign immed     = hit & ~defer;
  assign retire    = pending & insn_done & (insn_done_addr == pend_addr);
  assign brk_event = immed | retire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending   <= 1'b0;
      pend_addr <= '0;
    end else if (defer) begin
      pending   <= 1'b1;
      pend_addr <= bus_addr;
    end else if (retire) begin
      pending   <= 1'b0;
    end
  end

  // R11: pending only starts from a deferred fetch match
  a_r11_pend_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> $past(defer));
  // R11: retirement without a new deferral clears pending
  a_r11_retire_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && !defer) |=> !pending);
  // R10: an undeferred hit is an event in the same cycle
  a_r10_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !after_exec) |-> brk_event);

endmodule

// File: rtl/bkpt_pass_counter.sv
module bkpt_pass_counter #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          brk_event,
  input  logic          cnt_en,
  input  logic [CW-1:0] target,
  input  logic          target_wr,
  output logic          fire,
  output logic [CW-1:0] count
);

  // next occurrence reaches the target (target 0 acts as 1)
  function automatic logic reached(input logic [CW-1:0] c,
                                   input logic [CW-1:0] t);
    logic [CW:0] nxt;
    nxt = {1'b0, c} + {{CW{1'b0}}, 1'b1};
    return nxt >= {1'b0, t};
  endfunction

  logic take;

  assign take = brk_event & ~target_wr;
  assign fire = take & (~cnt_en | reached(count, target));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (target_wr) begin
      count <= '0;
    end else if (take && cnt_en) begin
      if (reached(count, target)) count <= '0;
      else                        count <= count + 1'b1;
    end
  end

  // R8: the count never sits at or above a nonzero target
  a_r8_below_target: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) || (count < target));
  // R9: a target write leaves the count at zero
  a_r9_wr_resets: assert property (@(posedge clk) disable iff (!rst_n)
    target_wr |=> (count == '0));
  // R9: no firing in a target-write cycle
  always_comb begin
    a_r9_no_fire_on_wr: assert (!(fire && target_wr));
  end

endmodule

// File: rtl/bus_break_channel.sv
module bus_break_channel
  import bkpt_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  input  logic          bus_valid,
  input  logic          bus_is_dma,
  input  logic          bus_fetch,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  input  logic          insn_done,
  input  logic [AW-1:0] insn_done_addr,
  output logic          brk_irq
);

  logic [AW-1:0] ref_addr, ref_mask;
  cond_t         cond;
  logic          cnt_en, after_exec, target_wr;
  logic [CW-1:0] target, occ_count;
  logic          hit, addr_ok, cpu_set, dma_set;
  logic          brk_event, pending, fire;

  bkpt_match #(.AW(AW)) u_match (
    .bus_valid (bus_valid),
    .bus_is_dma(bus_is_dma),
    .bus_fetch (bus_fetch),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .ref_addr  (ref_addr),
    .ref_mask  (ref_mask),
    .cond      (cond),
    .hit       (hit),
    .addr_ok   (addr_ok)
  );

  assign cpu_set = hit & ~bus_is_dma;
  assign dma_set = hit &  bus_is_dma;

  bkpt_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .cpu_set   (cpu_set),
    .dma_set   (dma_set),
    .occ_count (occ_count),
    .ref_addr  (ref_addr),
    .ref_mask  (ref_mask),
    .cond      (cond),
    .cnt_en    (cnt_en),
    .after_exec(after_exec),
    .target    (target),
    .target_wr (target_wr)
  );

  bkpt_exec_track #(.AW(AW)) u_track (
    .clk           (clk),
    .rst_n         (rst_n),
    .hit           (hit),
    .bus_fetch     (bus_fetch),
    .bus_addr      (bus_addr),
    .after_exec    (after_exec),
    .insn_done     (insn_done),
    .insn_done_addr(insn_done_addr),
    .brk_event     (brk_event),
    .pending       (pending)
  );

  bkpt_pass_counter #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .brk_event(brk_event),
    .cnt_en   (cnt_en),
    .target   (target),
    .target_wr(target_wr),
    .fire     (fire),
    .count    (occ_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) brk_irq <= 1'b0;
    else        brk_irq <= fire;
  end

  // R7: every interrupt pulse is backed by a break event
  a_r7_irq_from_event: assert property (@(posedge clk) disable iff (!rst_n)
    brk_irq |-> $past(brk_event));
  // R7: with counting off, an event always raises the request
  a_r7_event_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_event && !cnt_en && !target_wr) |=> brk_irq);
  // R11: nothing is pending while the deferral is unused and no fetch hit occurs
  a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && !(hit && bus_fetch && after_exec)) |=> !pending);

endmodule

// File: tb/bus_break_channel_tb.sv
module bus_break_channel_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        bus_valid = 1'b0, bus_is_dma = 1'b0, bus_fetch = 1'b0, bus_write = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        insn_done = 1'b0;
  logic [31:0] insn_done_addr = '0;
  logic        brk_irq;

  int tests = 0;
  int fails = 0;
  bit done_flag = 0;
  string cur_req = "R12";

  always #2 clk = ~clk;  // 250 MHz

  bus_break_channel u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid),
    .bus_is_dma(bus_is_dma), .bus_fetch(bus_fetch), .bus_write(bus_write),
    .bus_addr(bus_addr), .insn_done(insn_done), .insn_done_addr(insn_done_addr),
    .brk_irq(brk_irq)
  );

  // ---------------- reference model ----------------
  bit [31:0] m_addr, m_mask, m_paddr;
  bit [5:0]  m_cond;
  bit        m_cpuf, m_dmaf, m_cnten, m_after, m_pend, m_irq;
  int        m_tgt, m_cnt;

  always @(posedge clk) begin
    bit match, ev, defer, retire, fire;
    if (!rst_n) begin
      m_addr = 0; m_mask = 0; m_cond = 0; m_cpuf = 0; m_dmaf = 0;
      m_cnten = 0; m_after = 0; m_pend = 0; m_paddr = 0; m_irq = 0;
      m_tgt = 0; m_cnt = 0;
    end else begin
      match = bus_valid && (((bus_addr ^ m_addr) & ~m_mask) == 0)
              && (bus_is_dma ? m_cond[1] : m_cond[0])
              && (bus_fetch ? m_cond[2] : m_cond[3])
              && (bus_write ? m_cond[5] : m_cond[4]);
      defer  = match && bus_fetch && m_after;
      retire = m_pend && insn_done && (insn_done_addr == m_paddr);
      ev     = (match && !defer) || retire;
      fire   = 0;
      if (reg_we && reg_addr == 4) begin
        m_cnt = 0;
      end else if (ev) begin
        if (!m_cnten) fire = 1;
        else if (m_cnt + 1 >= m_tgt) begin fire = 1; m_cnt = 0; end
        else m_cnt = m_cnt + 1;
      end
      m_irq = fire;
      if (defer) begin m_pend = 1; m_paddr = bus_addr; end
      else if (retire) m_pend = 0;
      if (reg_we) begin
        case (reg_addr)
          0: m_addr = reg_wdata;
          1: m_mask = reg_wdata;
          2: m_cond = reg_wdata[5:0];
          3: begin
               m_cpuf  = m_cpuf & reg_wdata[0];
               m_dmaf  = m_dmaf & reg_wdata[1];
               m_cnten = reg_wdata[2];
               m_after = reg_wdata[3];
             end
          4: m_tgt = reg_wdata[11:0];
          default: ;
        endcase
      end
      if (match && !bus_is_dma) m_cpuf = 1;
      if (match &&  bus_is_dma) m_dmaf = 1;
    end
  end

  function automatic bit [31:0] model_read(input int a);
    case (a)
      0: return m_addr;
      1: return m_mask;
      2: return {26'b0, m_cond};
      3: return {28'b0, m_after, m_cnten, m_dmaf, m_cpuf};
      4: return m_tgt[31:0];
      5: return m_cnt[31:0];
      default: return 0;
    endcase
  endfunction

  // ---------------- per-cycle interrupt compare ----------------
  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      tests++;
      if (brk_irq !== m_irq) begin
        fails++;
        $display("FAIL %s brk_irq at %0t: got %0b expected %0b", cur_req, $time, brk_irq, m_irq);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle_inputs();
    reg_we = 0; bus_valid = 0; insn_done = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic wr(input int a, input bit [31:0] d);
    reg_we = 1; reg_addr = a[2:0]; reg_wdata = d;
    tick();
  endtask

  task automatic bus(input bit dma, input bit f, input bit w, input bit [31:0] a);
    bus_valid = 1; bus_is_dma = dma; bus_fetch = f; bus_write = w; bus_addr = a;
    tick();
  endtask

  task automatic done(input bit [31:0] a);
    insn_done = 1; insn_done_addr = a;
    tick();
  endtask

  task automatic rd_chk(input int a, input string req);
    bit [31:0] exp;
    reg_addr = a[2:0];
    #1;
    exp = model_read(a);
    tests++;
    if (reg_rdata !== exp) begin
      fails++;
      $display("FAIL %s read word %0d: got %h expected %h", req, a, reg_rdata, exp);
    end
  endtask

  task automatic rd_const(input int a, input bit [31:0] exp, input string req);
    reg_addr = a[2:0];
    #1;
    tests++;
    if (reg_rdata !== exp) begin
      fails++;
      $display("FAIL %s read word %0d: got %h expected %h", req, a, reg_rdata, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: got timeout expected completion");
    finish_run();
  end

  // ---------------- scenarios ----------------
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    // R12: reset values
    cur_req = "R12";
    for (int i = 0; i < 6; i++) rd_const(i, 32'h0, "R12");

    // R1/R7: masked address match on CPU read
    cur_req = "R1";
    wr(0, 32'h1000_0040);
    wr(1, 32'h0000_000F);
    wr(2, 32'h0000_003B);       // cpu|dma|data|rd|wr
    bus(0, 0, 0, 32'h1000_0047); // inside window
    rd_chk(3, "R3");            // R3: cpu flag set
    bus(0, 0, 0, 32'h1000_0050); // outside window -> no irq
    bus(0, 0, 0, 32'h1000_0040);
    bus(0, 0, 0, 32'h1000_0040); // back-to-back events, R7
    cur_req = "R4";
    bus(1, 0, 1, 32'h1000_0041); // DMA write
    rd_chk(3, "R4");
    tick();

    // R2: select bits gate the match
    cur_req = "R2";
    wr(2, 32'h0000_0038);       // no initiator allowed
    bus(0, 0, 0, 32'h1000_0040);
    bus(1, 0, 0, 32'h1000_0040);
    wr(2, 32'h0000_0019);       // cpu, data, read only
    bus(0, 0, 1, 32'h1000_0040); // write blocked
    bus(0, 1, 0, 32'h1000_0040); // fetch blocked
    bus(1, 0, 0, 32'h1000_0040); // dma blocked
    bus(0, 0, 0, 32'h1000_0040); // allowed
    wr(2, 32'hFFFF_FFC0);       // all pairs closed, upper bits dropped
    rd_chk(2, "R2");
    bus(0, 0, 0, 32'h1000_0040);
    wr(2, 32'h0000_003B);

    // R5: flag clear behaviour
    cur_req = "R5";
    wr(3, 32'h0000_0001);       // clear dma, keep cpu
    rd_chk(3, "R5");
    wr(3, 32'h0000_0003);       // ones do not set
    rd_chk(3, "R5");
    wr(3, 32'h0000_0000);
    rd_chk(3, "R5");
    // clear and set in the same cycle: set wins
    reg_we = 1; reg_addr = 3; reg_wdata = 0;
    bus(0, 0, 0, 32'h1000_0044);
    rd_chk(3, "R5");
    // R3: flag survives idle cycles
    tick(); tick();
    rd_chk(3, "R3");

    // R6: reserved control bits
    cur_req = "R6";
    wr(3, 32'hFFFF_FFF0);
    rd_chk(3, "R6");
    wr(3, 32'h0000_0000);

    // R8: count mode target 3
    cur_req = "R8";
    wr(4, 32'h0000_0003);
    wr(3, 32'h0000_0004);
    for (int k = 0; k < 7; k++) begin
      bus(0, 0, 0, 32'h1000_0042);
      rd_chk(5, "R8");
    end
    // target 0 acts as 1
    wr(4, 32'h0000_0000);
    bus(1, 0, 1, 32'h1000_0042);
    bus(1, 0, 1, 32'h1000_0042);
    rd_chk(5, "R8");

    // R9: target write resets and swallows a same-cycle event
    cur_req = "R9";
    wr(4, 32'h0000_0004);
    bus(0, 0, 0, 32'h1000_0042);
    bus(0, 0, 0, 32'h1000_0042);
    rd_chk(5, "R9");
    reg_we = 1; reg_addr = 4; reg_wdata = 32'h2;
    bus(0, 0, 0, 32'h1000_0042);
    rd_chk(5, "R9");
    bus(0, 0, 0, 32'h1000_0042);
    bus(0, 0, 0, 32'h1000_0042); // fires here
    rd_chk(5, "R9");
    wr(3, 32'h0000_0000);

    // R10: fetch break before execution
    cur_req = "R10";
    wr(2, 32'h0000_0015);       // cpu, fetch, read
    bus(0, 1, 0, 32'h1000_0048);
    tick();

    // R11: fetch break after execution
    cur_req = "R11";
    wr(3, 32'h0000_0008);
    bus(0, 1, 0, 32'h1000_0044);
    tick();
    done(32'h1000_0048);        // wrong address, no event
    done(32'h1000_0044);        // retire -> irq
    done(32'h1000_0044);        // already retired
    bus(0, 1, 0, 32'h1000_0041);
    bus(0, 1, 0, 32'h1000_0043); // replaces held address
    done(32'h1000_0041);
    done(32'h1000_0043);
    // data match stays immediate in after mode
    wr(2, 32'h0000_003B);
    bus(0, 0, 0, 32'h1000_0040);
    // after-exec combined with count
    wr(2, 32'h0000_0015);
    wr(4, 32'h0000_0002);
    wr(3, 32'h0000_000C);
    bus(0, 1, 0, 32'h1000_0046);
    done(32'h1000_0046);
    rd_chk(5, "R11");
    bus(0, 1, 0, 32'h1000_0046);
    done(32'h1000_0046);
    rd_chk(5, "R11");
    tick(); tick();

    finish_run();
  end

endmodule